// File: doc/BRIEF.md
# Paged Window Address Translator

This block turns 16-bit local CPU addresses into 23-bit global addresses for a 256 KB non-volatile data store. It holds one 8-bit page selector on a small register bus. A local access that lands in a 1 KB paged window is joined with that selector to pick one of 256 pages. A second 1 KB window sits directly above the paged one. That fixed window always points at the highest page, whatever the selector holds.

The reset value of the selector is one below the top page. So out of reset the two windows together give a linear 2 KB region. Any local address outside both windows is reported as a miss. For a miss the global address output is driven to zero, so that other decoders in the memory map can claim the access.

Translation is purely combinational from the current selector value. It has no handshake, because it has no state of its own and cannot stall. The register port uses plain write and read strobes. A register read returns its data in the same cycle.

Top module: `pgwin_xlate`

## Requirements
- R1: After a synchronous active-high reset, the page selector holds 0xFE, and a read at register address 0x0017 returns 0xFE.
- R2: A write with `reg_wr` high and `reg_addr` equal to 0x0017 loads `reg_wdata` into the page selector at that clock edge.
- R3: With `reg_rd` high and `reg_addr` equal to 0x0017, `reg_rdata` shows the selector in the same cycle. It reads 0 for any other register address, and it reads 0 whenever `reg_rd` is low.
- R4: A write to any register address other than 0x0017 leaves the selector unchanged.
- R5: For a local address in 0x0800–0x0BFF, `win_hit` is 1 and `glb_addr` equals {5'b00100, selector[7:0], cpu_addr[9:0]}. The fixed tag occupies bits 22:18, the page occupies bits 17:10 and the offset occupies bits 9:0.
- R6: For a local address in 0x0C00–0x0FFF, `win_hit` is 1 and `glb_addr` equals {5'b00100, 8'hFF, cpu_addr[9:0]}, whatever the selector holds.
- R7: For any local address outside 0x0800–0x0FFF, `win_hit` is 0 and `glb_addr` is 0. This holds for addresses whose low bits alias into a window.
- R8: A translation in the same cycle as a selector write uses the old selector value. The new value applies from the next cycle on.
- R9: With the reset selector value, local addresses 0x0800–0x0FFF map to the single linear global range 0x13F800–0x13FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 16 | Register bus address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| cpu_addr | input | 16 | Local CPU address to translate |
| win_hit | output | 1 | Local address falls in the paged or fixed window |
| glb_addr | output | 23 | Translated global address, zero on a miss |

## Verification
A selector write and a paged-window translation can fall in the same clock cycle. The bench provokes this by holding a paged local address steady while it drives a write strobe with a new page. It samples `glb_addr` just before the edge and expects the old page. It samples again after the edge and expects the new page. The same pattern is repeated with the register read strobe held high, so the bench can show that the read data switches on that same edge.

// File: rtl/pgwin_pkg.sv
package pgwin_pkg;
  // Decode result for one local address
  typedef enum logic [1:0] {
    WIN_NONE  = 2'd0,
    WIN_PAGED = 2'd1,
    WIN_FIXED = 2'd2
  } win_kind_e;
endpackage

// File: rtl/pgwin_index_reg.sv
module pgwin_index_reg #(
  parameter int               AW       = 16,
  parameter int               DW       = 8,
  parameter logic [AW-1:0]    SEL_ADDR = 16'h0017,
  parameter logic [DW-1:0]    SEL_INIT = 8'hFE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] page
);
  logic match;
  assign match = (addr == SEL_ADDR);

  always_ff @(posedge clk) begin
    if (rst)              page <= SEL_INIT;
    else if (wr && match) page <= wdata;
  end

  always_comb begin
    rdata = '0;
    if (rd && match) rdata = page;
  end
endmodule

// File: rtl/pgwin_decode.sv
module pgwin_decode
  import pgwin_pkg::*;
#(
  parameter int BLK_W     = 6,
  parameter int PAGED_BLK = 2
) (
  input  logic [BLK_W-1:0] blk,
  output win_kind_e        kind
);
  localparam logic [BLK_W-1:0] PAGED_B = BLK_W'(PAGED_BLK);
  localparam logic [BLK_W-1:0] FIXED_B = BLK_W'(PAGED_BLK + 1);

  always_comb begin
    if (blk == PAGED_B)      kind = WIN_PAGED;
    else if (blk == FIXED_B) kind = WIN_FIXED;
    else                     kind = WIN_NONE;
  end
endmodule

// File: rtl/pgwin_compose.sv
module pgwin_compose
  import pgwin_pkg::*;
#(
  parameter int              PAGE_W = 8,
  parameter int              OFF_W  = 10,
  parameter int              TAG_W  = 5,
  parameter logic [TAG_W-1:0] TAG   = 5'b00100
) (
  input  win_kind_e                   kind,
  input  logic [PAGE_W-1:0]           page,
  input  logic [OFF_W-1:0]            off,
  output logic                        hit,
  output logic [TAG_W+PAGE_W+OFF_W-1:0] gaddr
);
  localparam logic [PAGE_W-1:0] TOP_PAGE = '1;

  logic [PAGE_W-1:0] eff_page;

  always_comb begin
    hit      = (kind != WIN_NONE);
    eff_page = (kind == WIN_FIXED) ? TOP_PAGE : page;
    gaddr    = hit ? {TAG, eff_page, off} : '0;
  end
endmodule

// File: rtl/pgwin_xlate.sv
module pgwin_xlate #(
  parameter int                 LA_W      = 16,
  parameter int                 GA_W      = 23,
  parameter int                 PAGE_W    = 8,
  parameter int                 OFF_W     = 10,
  parameter int                 RA_W      = 16,
  parameter logic [RA_W-1:0]    SEL_ADDR  = 16'h0017,
  parameter logic [PAGE_W-1:0]  SEL_INIT  = 8'hFE,
  parameter logic [LA_W-1:0]    WIN_BASE  = 16'h0800,
  parameter logic [GA_W-PAGE_W-OFF_W-1:0] GTAG = 5'b00100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [PAGE_W-1:0] reg_wdata,
  output logic [PAGE_W-1:0] reg_rdata,
  input  logic [LA_W-1:0]   cpu_addr,
  output logic              win_hit,
  output logic [GA_W-1:0]   glb_addr
);
  import pgwin_pkg::*;

  localparam int TAG_W     = GA_W - PAGE_W - OFF_W;
  localparam int BLK_W     = LA_W - OFF_W;
  localparam int PAGED_BLK = int'(WIN_BASE >> OFF_W);

  logic [PAGE_W-1:0] page_q;
  win_kind_e         kind;

  pgwin_index_reg #(
    .AW(RA_W), .DW(PAGE_W), .SEL_ADDR(SEL_ADDR), .SEL_INIT(SEL_INIT)
  ) u_reg (
    .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
    .wdata(reg_wdata), .rdata(reg_rdata), .page(page_q)
  );

  pgwin_decode #(
    .BLK_W(BLK_W), .PAGED_BLK(PAGED_BLK)
  ) u_dec (
    .blk(cpu_addr[LA_W-1:OFF_W]), .kind(kind)
  );

  pgwin_compose #(
    .PAGE_W(PAGE_W), .OFF_W(OFF_W), .TAG_W(TAG_W), .TAG(GTAG)
  ) u_cmp (
    .kind(kind), .page(page_q), .off(cpu_addr[OFF_W-1:0]),
    .hit(win_hit), .gaddr(glb_addr)
  );
endmodule

// File: rtl/pgwin_xlate_chk.sv
module pgwin_xlate_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] reg_addr,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [7:0]  reg_wdata,
  input logic [7:0]  reg_rdata,
  input logic [15:0] cpu_addr,
  input logic        win_hit,
  input logic [22:0] glb_addr,
  input logic [7:0]  page_q
);
  // R1
  a_r1_reset_value: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> page_q == 8'hFE);
  // R2
  a_r2_write_loads: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 16'h0017) |=> page_q == $past(reg_wdata));
  // R4
  a_r4_other_write_holds: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_addr == 16'h0017) |=> $stable(page_q));
  // R3
  a_r3_read_other_zero: assert property (@(posedge clk) disable iff (rst)
    (!reg_rd || reg_addr != 16'h0017) |-> reg_rdata == 8'h00);
  // R5
  a_r5_paged_map: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr[15:10] == 6'd2) |-> (win_hit && glb_addr[22:18] == 5'b00100
      && glb_addr[17:10] == page_q && glb_addr[9:0] == cpu_addr[9:0]));
  // R6
  a_r6_fixed_map: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr[15:10] == 6'd3) |-> (win_hit && glb_addr[17:10] == 8'hFF
      && glb_addr[9:0] == cpu_addr[9:0]));
  // R7
  a_r7_miss_zero: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr < 16'h0800 || cpu_addr > 16'h0FFF) |-> (!win_hit && glb_addr == 23'd0));
endmodule

bind pgwin_xlate pgwin_xlate_chk u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_addr(cpu_addr),
  .win_hit(win_hit), .glb_addr(glb_addr), .page_q(page_q)
);

// File: tb/pgwin_xlate_test.sv
`timescale 1ns/1ps
module pgwin_xlate_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [15:0] cpu_addr = '0;
  logic        win_hit;
  logic [22:0] glb_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pgwin_xlate uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_addr(cpu_addr),
    .win_hit(win_hit), .glb_addr(glb_addr)
  );

  // {cpu_addr, hit, glb_addr} with selector = 0x5A
  localparam int NV = 11;
  localparam logic [39:0] VEC [NV] = '{
    {16'h0800, 1'b1, 23'h116800},   // R5 bottom
    {16'h0BFF, 1'b1, 23'h116BFF},   // R5 top
    {16'h0A35, 1'b1, 23'h116A35},   // R5 middle
    {16'h0C00, 1'b1, 23'h13FC00},   // R6 bottom
    {16'h0FFF, 1'b1, 23'h13FFFF},   // R6 top
    {16'h0D12, 1'b1, 23'h13FD12},   // R6 middle
    {16'h07FF, 1'b0, 23'h000000},   // R7 just below
    {16'h1000, 1'b0, 23'h000000},   // R7 just above
    {16'h0000, 1'b0, 23'h000000},   // R7
    {16'hFFFF, 1'b0, 23'h000000},   // R7
    {16'h4800, 1'b0, 23'h000000}    // R7 alias
  };

  task automatic chk_tr(input string req, input logic eh, input logic [22:0] eg);
    checks++;
    if (win_hit !== eh || glb_addr !== eg) begin
      fails++;
      $display("FAIL %s addr=%h hit=%b glb=%h expected hit=%b glb=%h",
               req, cpu_addr, win_hit, glb_addr, eh, eg);
    end
  endtask

  task automatic chk_rd(input string req, input logic [7:0] exp);
    checks++;
    if (reg_rdata !== exp) begin
      fails++;
      $display("FAIL %s rdata=%h expected %h", req, reg_rdata, exp);
    end
  endtask

  task automatic reg_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input string req, input logic [15:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 chk_rd(req, exp);
    reg_rd = 1'b0;
  endtask

  task automatic xlate(input string req, input logic [15:0] a,
                       input logic eh, input logic [22:0] eg);
    @(negedge clk);
    cpu_addr = a;
    #1 chk_tr(req, eh, eg);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R9 reset state
    reg_read("R1", 16'h0017, 8'hFE);
    xlate("R9", 16'h0800, 1'b1, 23'h13F800);
    xlate("R9", 16'h0BFF, 1'b1, 23'h13FBFF);
    xlate("R9", 16'h0C00, 1'b1, 23'h13FC00);
    xlate("R9", 16'h0FFF, 1'b1, 23'h13FFFF);

    // R3 read rules
    reg_read("R3", 16'h0016, 8'h00);
    @(negedge clk); reg_addr = 16'h0017; reg_rd = 1'b0;
    #1 chk_rd("R3", 8'h00);

    // R4 foreign write ignored
    reg_write(16'h0016, 8'h33);
    reg_write(16'h0117, 8'h44);
    reg_read("R4", 16'h0017, 8'hFE);
    xlate("R4", 16'h0900, 1'b1, 23'h13F900);

    // R2 write, then table walk
    reg_write(16'h0017, 8'h5A);
    reg_read("R2", 16'h0017, 8'h5A);
    for (int i = 0; i < NV; i++) begin
      xlate("R5/R6/R7 table", VEC[i][39:24], VEC[i][23], VEC[i][22:0]);
    end

    // R8 write and translate in the same cycle
    @(negedge clk);
    cpu_addr = 16'h0801; reg_addr = 16'h0017; reg_wdata = 8'h21;
    reg_wr = 1'b1; reg_rd = 1'b1;
    #1 chk_tr("R8 old page", 1'b1, 23'h116801);
    chk_rd("R8 old read", 8'h5A);
    @(negedge clk);
    reg_wr = 1'b0;
    #1 chk_tr("R8 new page", 1'b1, 23'h108401);
    chk_rd("R8 new read", 8'h21);
    reg_rd = 1'b0;

    // R5 page extremes, R6 independent of selector
    reg_write(16'h0017, 8'h00);
    xlate("R5 page0", 16'h0800, 1'b1, 23'h100000);
    xlate("R6 sel0", 16'h0C05, 1'b1, 23'h13FC05);
    reg_write(16'h0017, 8'hFF);
    xlate("R5 pageFF", 16'h0800, 1'b1, 23'h13FC00);

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    reg_read("R1 rerst", 16'h0017, 8'hFE);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule